// File: doc/BRIEF.md
# Reset and Ready Sequencer

This block produces the internal reset for the core logic and for the PHY of a network controller, together with a READY flag that host software reads. Five sources can start a reset or stall readiness: power-on, a filtered and synchronised active-low reset pin, a self-clearing soft-reset bit, a wake from power-down caused by a host write, and a self-clearing PHY reset bit. The PHY reset bit can be set in either of two registers. The block times each source with a cycle counter whose length is a parameter, so one netlist can serve any clock rate.

The host reaches the block through a small word-addressed register port. Writes go through only while READY is high. The one exception is a write to the pattern register while the block is powered down, which starts the wake. The configuration register has two fields: a volatile field that a soft reset clears, and a preserved field that only power-on and pin resets clear. The PHY reset runs on its own timer, and the core keeps running while it is active.

The sources have a fixed priority: power-on first, then the pin, then soft reset, then wake. An accepted pin reset overrides a soft reset, a wake or a PHY reset that is in progress, and it clears all stored state.

Top module: `rst_ready_seq`

## Requirements

- R1: When `powerGood` rises, `coreRst` stays high and `ready` stays low for exactly `POR_CYC` cycles. After that, `ready` is 1 and both configuration fields read 0.
- R2: `ready` is 1 only when no core reset, power-down or wake is in progress, and `coreRst` is never high while `ready` is 1. While `ready` is 0, host writes to the configuration register have no effect.
- R3: The reset pin is taken through a two-flop synchroniser. A low level lasting at least `PIN_MIN_CYC` synchronised cycles is accepted: `coreRst` goes high, `phyRst` goes high, and the volatile field (bits 15:8 of address 1) and the preserved field (bits 23:16 of address 1) are both cleared. A shorter low pulse leaves `ready` and both fields unchanged.
- R4: After an accepted pin reset is released, `ready` returns between `PIN_REL_CYC`+1 and `PIN_REL_CYC`+4 cycles after the pin goes high.
- R5: Writing 1 to bit 0 of address 1 while ready starts a soft reset. `coreRst` is high and `ready` is low for exactly `SOFT_CYC` cycles, counted from the write edge, and bit 0 of address 1 reads 1 for that whole time.
- R6: A soft reset clears the volatile field (bits 15:8 of address 1) and leaves the preserved field (bits 23:16 of address 1) unchanged.
- R7: Writing 1 to bit 1 of address 2 while ready enters power-down. In power-down `ready` is 0, `coreRst` is 0, and bit 1 of address 2 reads 1. Any write to address 0 while powered down starts a wake, and `ready` returns exactly `WAKE_CYC` cycles after that write edge.
- R8: Writing 1 to bit 10 of address 2 while ready drives `phyRst` high for exactly `PHY_CYC` cycles. Bit 10 reads 1 during that time, and `ready` stays 1 throughout.
- R9: Writing 1 to bit 15 of address 3 starts the same PHY reset. Bit 15 of address 3 reads 1 while the PHY reset runs and reads 0 once it is over.
- R10: A PHY reset request made while a PHY reset is already running is ignored and does not extend it.
- R11: An accepted pin reset during a soft reset or a PHY reset takes over. The preserved field is cleared, `phyRst` is held high during the hard reset, and the PHY timer is cancelled, so `phyRst` is low and bit 10 of address 2 reads 0 once the hard reset ends.
- R12: Address 0 always reads the fixed value `PATTERN`. Bit 0 of address 2 reads the READY flag.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| powerGood | input | 1 | Power detector output; low holds everything in power-on reset |
| extRstN | input | 1 | Asynchronous active-low reset pin; high when unused |
| hostWrEn | input | 1 | Host write strobe for one cycle |
| hostAddr | input | 2 | Host word address |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Read data for `hostAddr` (combinational) |
| coreRst | output | 1 | Active-high reset for the core logic |
| phyRst | output | 1 | Active-high reset for the PHY |
| ready | output | 1 | Core configured-and-running flag |

## Verification

A wrong sequencer state shows up at the ports straight away. `ready` and `coreRst` are decoded from that state, so the next sample after the faulty edge shows a stray value on `ready` or a stray pulse on `coreRst`. A counter that is off by one changes the measured low time of `ready`, or the high time of `coreRst` or `phyRst`, by exactly that cycle. A filter or field-clearing fault only shows at the next register read: the preserved or volatile field reads a stale value, or a short pin glitch makes `ready` drop.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR,
    ST_PIN,
    ST_SOFT,
    ST_RUN,
    ST_SLEEP,
    ST_WAKE
  } seqState_t;

  // Strobes from the control side to the register datapath
  typedef struct packed {
    logic hardClr;   // power-on or pin reset active: clear everything
    logic softClr;   // soft reset active: clear volatile state
    logic wrOpen;    // host writes accepted (READY)
    logic sleeping;  // powered down, waiting for wake write
  } seqStrobe_t;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_PATTERN = 2'd0;
  localparam logic [ADDR_W-1:0] A_HWCFG   = 2'd1;
  localparam logic [ADDR_W-1:0] A_PMCTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_PHYCTRL = 2'd3;

  localparam int unsigned SOFT_BIT   = 0;
  localparam int unsigned READY_BIT  = 0;
  localparam int unsigned SLEEP_BIT  = 1;
  localparam int unsigned PHYRST_BIT = 10;
  localparam int unsigned PHYSW_BIT  = 15;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned VOL_LO     = 8;
  localparam int unsigned KEEP_LO    = 16;

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_CYC     = 100
) (
  input  logic clk,
  input  logic powerGood,
  input  logic extRstN,
  output logic pinHold
);

  localparam int unsigned LW = (MIN_CYC < 2) ? 1 : $clog2(MIN_CYC);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [LW-1:0]          lowCnt;
  logic                   accepted;
  logic                   pinLow;

  assign pinLow  = ~syncQ[SYNC_STAGES-1];
  assign pinHold = accepted;

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      syncQ <= '1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], extRstN};
    end
  end

  // Count synchronised low cycles; accept on the MIN_CYC-th one
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      lowCnt   <= '0;
      accepted <= 1'b0;
    end else if (!pinLow) begin
      lowCnt   <= '0;
      accepted <= 1'b0;
    end else if (!accepted) begin
      if (lowCnt == LW'(MIN_CYC - 1)) begin
        accepted <= 1'b1;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned POR_CYC     = 2200000,
  parameter int unsigned PIN_REL_CYC = 4,
  parameter int unsigned SOFT_CYC    = 200,
  parameter int unsigned WAKE_CYC    = 200000
) (
  input  logic       clk,
  input  logic       powerGood,
  input  logic       pinHold,
  input  logic       softReq,
  input  logic       sleepReq,
  input  logic       wakeReq,
  output seqStrobe_t strobe,
  output logic       coreRst,
  output logic       ready
);

  localparam int unsigned MAX_A   = (POR_CYC > SOFT_CYC) ? POR_CYC : SOFT_CYC;
  localparam int unsigned MAX_B   = (WAKE_CYC > PIN_REL_CYC) ? WAKE_CYC : PIN_REL_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  localparam logic [CW-1:0] POR_LOAD  = CW'(POR_CYC - 1);
  localparam logic [CW-1:0] REL_LOAD  = CW'(PIN_REL_CYC - 1);
  localparam logic [CW-1:0] SOFT_LOAD = CW'(SOFT_CYC - 1);
  localparam logic [CW-1:0] WAKE_LOAD = CW'(WAKE_CYC - 1);

  seqState_t     state, stateNext;
  logic [CW-1:0] cnt, cntNext;
  logic          cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    if (state == ST_POR) begin
      if (cntDone) begin
        if (pinHold) begin
          stateNext = ST_PIN;
          cntNext   = REL_LOAD;
        end else begin
          stateNext = ST_RUN;
        end
      end else begin
        cntNext = cnt - 1'b1;
      end
    end else if (pinHold) begin
      // pin outranks soft reset, wake and running
      stateNext = ST_PIN;
      cntNext   = REL_LOAD;
    end else begin
      unique case (state)
        ST_PIN, ST_SOFT, ST_WAKE: begin
          if (cntDone) stateNext = ST_RUN;
          else         cntNext   = cnt - 1'b1;
        end
        ST_RUN: begin
          if (softReq) begin
            stateNext = ST_SOFT;
            cntNext   = SOFT_LOAD;
          end else if (sleepReq) begin
            stateNext = ST_SLEEP;
          end
        end
        ST_SLEEP: begin
          if (wakeReq) begin
            stateNext = ST_WAKE;
            cntNext   = WAKE_LOAD;
          end
        end
        default: begin
          stateNext = ST_POR;
          cntNext   = POR_LOAD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      state <= ST_POR;
      cnt   <= POR_LOAD;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign strobe.hardClr  = (state == ST_POR) || (state == ST_PIN);
  assign strobe.softClr  = (state == ST_SOFT);
  assign strobe.wrOpen   = (state == ST_RUN);
  assign strobe.sleeping = (state == ST_SLEEP);

  assign coreRst = strobe.hardClr || strobe.softClr;
  assign ready   = strobe.wrOpen;

endmodule

// File: rtl/rst_seq_regs.sv
module rst_seq_regs
  import rst_seq_pkg::*;
#(
  parameter int unsigned PHY_CYC = 10000,
  parameter logic [31:0] PATTERN = 32'hC0DE_5A17
) (
  input  logic              clk,
  input  logic              powerGood,
  input  seqStrobe_t        strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              softReq,
  output logic              sleepReq,
  output logic              wakeReq,
  output logic              phyRst
);

  localparam int unsigned PW = $clog2(PHY_CYC + 1);
  localparam logic [PW-1:0] PHY_LOAD = PW'(PHY_CYC - 1);

  logic [FIELD_W-1:0] cfgVol, cfgKeep;
  logic [PW-1:0]      phyCnt;
  logic               phyBusy;
  logic               wrOk, phyKick;
  logic               unusedWrBits;

  assign unusedWrBits = ^{wrData[31:24], wrData[7:2]};

  assign wrOk     = wrEn && strobe.wrOpen;
  assign softReq  = wrOk && (addr == A_HWCFG) && wrData[SOFT_BIT];
  assign sleepReq = wrOk && (addr == A_PMCTRL) && wrData[SLEEP_BIT];
  assign wakeReq  = wrEn && strobe.sleeping && (addr == A_PATTERN);
  assign phyKick  = wrOk && !phyBusy &&
                    (((addr == A_PMCTRL) && wrData[PHYRST_BIT]) ||
                     ((addr == A_PHYCTRL) && wrData[PHYSW_BIT]));

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      cfgVol  <= '0;
      cfgKeep <= '0;
    end else if (strobe.hardClr) begin
      cfgVol  <= '0;
      cfgKeep <= '0;
    end else if (strobe.softClr) begin
      cfgVol  <= '0;
    end else if (wrOk && (addr == A_HWCFG)) begin
      cfgVol  <= wrData[VOL_LO +: FIELD_W];
      cfgKeep <= wrData[KEEP_LO +: FIELD_W];
    end
  end

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      phyBusy <= 1'b0;
      phyCnt  <= '0;
    end else if (strobe.hardClr) begin
      phyBusy <= 1'b0;
      phyCnt  <= '0;
    end else if (phyKick) begin
      phyBusy <= 1'b1;
      phyCnt  <= PHY_LOAD;
    end else if (phyBusy) begin
      if (phyCnt == '0) phyBusy <= 1'b0;
      else              phyCnt  <= phyCnt - 1'b1;
    end
  end

  assign phyRst = phyBusy || strobe.hardClr;

  always_comb begin
    rdData = '0;
    unique case (addr)
      A_PATTERN: rdData = PATTERN;
      A_HWCFG: begin
        rdData[SOFT_BIT]             = strobe.softClr;
        rdData[VOL_LO +: FIELD_W]    = cfgVol;
        rdData[KEEP_LO +: FIELD_W]   = cfgKeep;
      end
      A_PMCTRL: begin
        rdData[READY_BIT]  = strobe.wrOpen;
        rdData[SLEEP_BIT]  = strobe.sleeping;
        rdData[PHYRST_BIT] = phyBusy;
      end
      A_PHYCTRL: rdData[PHYSW_BIT] = phyBusy;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/rst_ready_seq.sv
module rst_ready_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned POR_CYC     = 2200000,
  parameter int unsigned PIN_MIN_CYC = 100,
  parameter int unsigned PIN_REL_CYC = 4,
  parameter int unsigned SOFT_CYC    = 200,
  parameter int unsigned WAKE_CYC    = 200000,
  parameter int unsigned PHY_CYC     = 10000,
  parameter logic [31:0] PATTERN     = 32'hC0DE_5A17
) (
  input  logic        clk,
  input  logic        powerGood,
  input  logic        extRstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic        coreRst,
  output logic        phyRst,
  output logic        ready
);

  seqStrobe_t strobe;
  logic       pinHold, softReq, sleepReq, wakeReq;

  rst_pin_filter #(
    .SYNC_STAGES(2),
    .MIN_CYC    (PIN_MIN_CYC)
  ) u_pin (
    .clk      (clk),
    .powerGood(powerGood),
    .extRstN  (extRstN),
    .pinHold  (pinHold)
  );

  rst_seq_ctrl #(
    .POR_CYC    (POR_CYC),
    .PIN_REL_CYC(PIN_REL_CYC),
    .SOFT_CYC   (SOFT_CYC),
    .WAKE_CYC   (WAKE_CYC)
  ) u_ctrl (
    .clk      (clk),
    .powerGood(powerGood),
    .pinHold  (pinHold),
    .softReq  (softReq),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .strobe   (strobe),
    .coreRst  (coreRst),
    .ready    (ready)
  );

  rst_seq_regs #(
    .PHY_CYC(PHY_CYC),
    .PATTERN(PATTERN)
  ) u_regs (
    .clk      (clk),
    .powerGood(powerGood),
    .strobe   (strobe),
    .wrEn     (hostWrEn),
    .addr     (hostAddr),
    .wrData   (hostWrData),
    .rdData   (hostRdData),
    .softReq  (softReq),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .phyRst   (phyRst)
  );

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
  import rst_seq_pkg::*;
#(
  parameter int unsigned POR_CYC = 2200000,
  parameter int unsigned PHY_CYC = 10000
) (
  input logic       clk,
  input logic       powerGood,
  input logic       coreRst,
  input logic       ready,
  input logic       phyRst,
  input logic [1:0] hostAddr,
  input logic [7:0] keepView,
  input seqStrobe_t strobe
);

  localparam int unsigned SW = $clog2(POR_CYC + 1);
  localparam int unsigned RW = $clog2(PHY_CYC + 2);

  logic [SW-1:0] sinceRst;
  logic [RW-1:0] phyRun;

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) sinceRst <= '0;
    else if (sinceRst < SW'(POR_CYC)) sinceRst <= sinceRst + 1'b1;
  end

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) phyRun <= '0;
    else if (!phyRst || strobe.hardClr) phyRun <= '0;
    else if (phyRun <= RW'(PHY_CYC)) phyRun <= phyRun + 1'b1;
  end

  // R1: core reset held for the whole power-on window
  p_por_hold_r1: assert property (@(posedge clk) disable iff (!powerGood)
    (sinceRst < SW'(POR_CYC)) |-> coreRst);

  // R2: ready and core reset are never both high
  p_ready_excl_r2: assert property (@(posedge clk) disable iff (!powerGood)
    ready |-> !coreRst);

  // R6: preserved field stable across a soft reset
  p_keep_soft_r6: assert property (@(posedge clk) disable iff (!powerGood)
    (strobe.softClr && $past(strobe.softClr) && hostAddr == A_HWCFG &&
     $past(hostAddr) == A_HWCFG) |-> $stable(keepView));

  // R7: leaving power-down never makes ready high at once
  p_wake_delay_r7: assert property (@(posedge clk) disable iff (!powerGood)
    ($past(strobe.sleeping) && !strobe.sleeping) |-> !ready);

  // R10: a PHY reset outside hard reset never outlasts its window
  p_phy_len_r10: assert property (@(posedge clk) disable iff (!powerGood)
    phyRun <= RW'(PHY_CYC));

  // R11: PHY timer is cancelled by the end of a hard reset
  p_phy_cancel_r11: assert property (@(posedge clk) disable iff (!powerGood)
    ($past(strobe.hardClr) && !strobe.hardClr) |-> !phyRst);

endmodule

bind rst_ready_seq rst_seq_chk #(
  .POR_CYC(POR_CYC),
  .PHY_CYC(PHY_CYC)
) u_chk (
  .clk      (clk),
  .powerGood(powerGood),
  .coreRst  (coreRst),
  .ready    (ready),
  .phyRst   (phyRst),
  .hostAddr (hostAddr),
  .keepView (hostRdData[23:16]),
  .strobe   (strobe)
);

// File: tb/test_rst_ready_seq.sv
module test_rst_ready_seq;

  localparam int unsigned POR_CYC     = 40;
  localparam int unsigned PIN_MIN_CYC = 6;
  localparam int unsigned PIN_REL_CYC = 3;
  localparam int unsigned SOFT_CYC    = 12;
  localparam int unsigned WAKE_CYC    = 25;
  localparam int unsigned PHY_CYC     = 30;
  localparam logic [31:0] PATTERN     = 32'hC0DE_5A17;

  logic        clk = 1'b0;
  logic        powerGood = 1'b0;
  logic        extRstN = 1'b1;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        coreRst, phyRst, ready;
  logic        rdStrobe = 1'b0;

  int total = 0;
  int failed = 0;

  typedef struct {
    string       tag;
    logic [31:0] mask;
    logic [31:0] exp;
  } rdItem_t;

  rdItem_t expQ[$];

  always #5 clk = ~clk;

  rst_ready_seq #(
    .POR_CYC    (POR_CYC),
    .PIN_MIN_CYC(PIN_MIN_CYC),
    .PIN_REL_CYC(PIN_REL_CYC),
    .SOFT_CYC   (SOFT_CYC),
    .WAKE_CYC   (WAKE_CYC),
    .PHY_CYC    (PHY_CYC),
    .PATTERN    (PATTERN)
  ) i_rst_ready_seq (
    .clk       (clk),
    .powerGood (powerGood),
    .extRstN   (extRstN),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .hostRdData(hostRdData),
    .coreRst   (coreRst),
    .phyRst    (phyRst),
    .ready     (ready)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkRange(input string tag, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // Monitor: pops expected read items and compares them
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rdStrobe && expQ.size() > 0) begin
        rdItem_t it;
        it = expQ.pop_front();
        total++;
        if ((hostRdData & it.mask) !== it.exp) begin
          failed++;
          $display("FAIL %s: actual %h expected %h", it.tag,
                   hostRdData & it.mask, it.exp);
        end
      end
    end
  end

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    hostWrEn   = 1'b1;
    hostAddr   = a;
    hostWrData = d;
    @(negedge clk);
    hostWrEn   = 1'b0;
  endtask

  task automatic hostRead(input string tag, input logic [1:0] a,
                          input logic [31:0] mask, input logic [31:0] exp);
    rdItem_t it;
    it.tag  = tag;
    it.mask = mask;
    it.exp  = exp;
    expQ.push_back(it);
    hostAddr = a;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  // sel: 0 coreRst high, 1 ready low, 2 phyRst high
  task automatic measure(input int sel, output int n);
    n = 0;
    while (n < 1000 && ((sel == 0 && coreRst) || (sel == 1 && !ready) ||
                        (sel == 2 && phyRst))) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pinPulse(input int len);
    extRstN = 1'b0;
    repeat (len) @(negedge clk);
    extRstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    int lowSeen;
    repeat (3) @(negedge clk);
    check("R1 reset coreRst", int'(coreRst), 1);
    check("R1 reset ready", int'(ready), 0);

    // R1 power-on window
    powerGood = 1'b1;
    measure(0, n);
    check("R1 por length", n, POR_CYC);
    check("R1 ready after por", int'(ready), 1);
    hostRead("R1 cfg cleared", 2'd1, 32'h00FF_FF01, 32'h0);
    hostRead("R12 pattern", 2'd0, 32'hFFFF_FFFF, PATTERN);
    hostRead("R12 ready bit", 2'd2, 32'h0000_0403, 32'h0000_0001);

    // R5/R6 soft reset, R2 writes ignored while not ready
    hostWrite(2'd1, 32'h005A_3C00);
    hostRead("R2 cfg written", 2'd1, 32'h00FF_FF01, 32'h005A_3C00);
    hostWrite(2'd1, 32'h005A_3C01);
    hostRead("R5 busy bit and R6 vol cleared", 2'd1, 32'h00FF_FF01, 32'h005A_0001);
    hostWrite(2'd1, 32'h00FF_FF00);
    measure(1, n);
    check("R5 soft length", n, SOFT_CYC - 2);
    check("R5 coreRst released", int'(coreRst), 0);
    hostRead("R6 keep held, R2 write ignored", 2'd1, 32'h00FF_FF01, 32'h005A_0000);

    // R8 PHY reset via power register
    hostWrite(2'd2, 32'h0000_0400);
    check("R8 ready during phy", int'(ready), 1);
    hostRead("R8 bit10 set", 2'd2, 32'h0000_0401, 32'h0000_0401);
    measure(2, n);
    check("R8 phy length", n, PHY_CYC - 1);
    hostRead("R8 bit10 clear", 2'd2, 32'h0000_0400, 32'h0);

    // R9 / R10 PHY reset via PHY register, retrigger ignored
    hostWrite(2'd3, 32'h0000_8000);
    repeat (9) @(negedge clk);
    hostRead("R9 bit15 set", 2'd3, 32'h0000_8000, 32'h0000_8000);
    hostWrite(2'd2, 32'h0000_0400);
    measure(2, n);
    check("R10 no extension", n, PHY_CYC - 11);
    hostRead("R9 bit15 clear", 2'd3, 32'h0000_8000, 32'h0);

    // R7 power-down and wake
    hostWrite(2'd2, 32'h0000_0002);
    check("R7 ready low asleep", int'(ready), 0);
    check("R7 coreRst low asleep", int'(coreRst), 0);
    hostRead("R7 sleep bit", 2'd2, 32'h0000_0003, 32'h0000_0002);
    repeat (5) @(negedge clk);
    check("R7 still asleep", int'(ready), 0);
    hostWrite(2'd0, 32'h0);
    measure(1, n);
    check("R7 wake length", n, WAKE_CYC);
    hostRead("R7 awake", 2'd2, 32'h0000_0003, 32'h0000_0001);

    // R3 short pin pulse ignored
    lowSeen = 0;
    extRstN = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (i == PIN_MIN_CYC - 1) extRstN = 1'b1;
      if (!ready) lowSeen++;
      @(negedge clk);
    end
    check("R3 short pulse ready", lowSeen, 0);
    hostRead("R3 short pulse fields", 2'd1, 32'h00FF_FF00, 32'h005A_0000);

    // R3 / R4 accepted pin reset
    hostWrite(2'd1, 32'h005A_3C00);
    extRstN = 1'b0;
    repeat (PIN_MIN_CYC + 4) @(negedge clk);
    check("R3 coreRst on pin", int'(coreRst), 1);
    check("R3 phyRst on pin", int'(phyRst), 1);
    extRstN = 1'b1;
    measure(1, n);
    checkRange("R4 release delay", n, PIN_REL_CYC + 1, PIN_REL_CYC + 4);
    hostRead("R3 fields cleared", 2'd1, 32'h00FF_FF00, 32'h0);

    // R11 pin during soft reset clears preserved field
    hostWrite(2'd1, 32'h0066_0000);
    hostWrite(2'd1, 32'h0066_0001);
    repeat (2) @(negedge clk);
    pinPulse(PIN_MIN_CYC + 4);
    measure(1, n);
    hostRead("R11 keep cleared", 2'd1, 32'h00FF_FF00, 32'h0);

    // R11 pin during PHY reset cancels it
    hostWrite(2'd2, 32'h0000_0400);
    repeat (3) @(negedge clk);
    extRstN = 1'b0;
    repeat (PIN_MIN_CYC + 4) @(negedge clk);
    check("R11 phyRst in hard reset", int'(phyRst), 1);
    extRstN = 1'b1;
    measure(1, n);
    repeat (2) @(negedge clk);
    check("R11 phy cancelled", int'(phyRst), 0);
    hostRead("R11 bit10 clear", 2'd2, 32'h0000_0401, 32'h0000_0001);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule